// File: doc/BRIEF.md
# Peripheral Interrupt Collector with Keyed Soft Reset

This block sits next to a peripheral core and turns the core's event pulses into one level-sensitive interrupt. Each rising edge on an event input sets a sticky bit in a status register. The status register is cleared by writing ones to it. A per-source enable register and a single global enable bit both mask these bits before they are combined into `irq_o`. Software reads the status, writes the same value back to acknowledge it, and can mask individual sources or all of them.

The unit also owns the core's reset. Writing one fixed key value to the reset register does two things:
- it drives `core_rst_o` high for a parameterised number of cycles;
- it returns the unit's own status, enable and global-enable registers to zero.

Any other value written there is ignored. The register bus is a plain single-cycle write strobe with a combinational read port.

Register offsets: global enable 0x1C, status 0x20, per-source enable 0x28, reset 0x40.

Top module: `intc_softrst_top`

## Requirements
- R1: After hardware reset, status, per-source enable and global enable read as zero, and `irq_o` and `core_rst_o` are low.
- R2: A 0-to-1 transition on `event_i[i]` sets status bit i at the next clock edge, whatever the enable settings are. An event input held high does not set the bit again once it has been cleared.
- R3: Writing to the status register (0x20) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When an event edge and a write-1-to-clear of the same bit land in the same cycle, the bit stays set. Other bits in that write are still cleared.
- R5: The per-source enable register (0x28) holds bits [NUM_SRC-1:0] of the written data. Higher bits read as 0.
- R6: The global enable register (0x1C) stores only bit 31 and reads back as {bit31, 31'b0}. The other data bits are ignored.
- R7: `irq_o` is high exactly when the global enable is set and at least one source has both its status bit and its enable bit set.
- R8: Writing exactly 0x0000000A to the reset register (0x40) drives `core_rst_o` high for RST_CYCLES consecutive cycles, starting in the cycle after the write.
- R9: The key write also clears status, per-source enable and global enable. These registers are held at zero while `core_rst_o` is high.
- R10: Writing any other value to the reset register leaves `core_rst_o` low and all register contents unchanged.
- R11: Writes to unmapped offsets change nothing. Reads of unmapped offsets, and of the reset register, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| event_i | input | NUM_SRC | Event lines from the core |
| irq_o | output | 1 | Level-sensitive interrupt request |
| core_rst_o | output | 1 | Active-high reset pulse to the core |

## Verification
The hardest case to reach from the ports is an event edge that collides with a write-1-to-clear of the same bit. The bench raises the event line on the same falling edge that it presents the status write, so both take effect at one clock edge. It then reads back which bits survived. A second hard-to-reach case is a held-high event line after its bit has been cleared; the bench holds the line across the clearing write and several further cycles. The interrupt combination is swept over every enable value, with both global-enable settings and a computed event pattern for each.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam logic [7:0]  OFS_GIE  = 8'h1C;
   localparam logic [7:0]  OFS_STAT = 8'h20;
   localparam logic [7:0]  OFS_EN   = 8'h28;
   localparam logic [7:0]  OFS_RST  = 8'h40;
   localparam int          GIE_BIT  = 31;
   localparam logic [31:0] RST_KEY  = 32'h0000_000A;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_GIE,
      SEL_STAT,
      SEL_EN,
      SEL_RST
   } reg_sel_e;
endpackage

// File: rtl/intc_edge_capture.sv
module intc_edge_capture #(
   parameter int NUM_SRC = 7
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] event_i,
   output logic [NUM_SRC-1:0] rise_o
);
   logic [NUM_SRC-1:0] prev_q;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) prev_q[i] <= 1'b0;
         else         prev_q[i] <= event_i[i];
      end
      assign rise_o[i] = event_i[i] & ~prev_q[i];
   end

   // R2: a bit cannot present a rising edge in two consecutive cycles
   p_single_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/intc_status_regs.sv
module intc_status_regs #(
   parameter int NUM_SRC = 7,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               clr_i,
   input  logic [NUM_SRC-1:0] rise_i,
   input  logic               stat_wr_i,
   input  logic               en_wr_i,
   input  logic               gie_wr_i,
   input  logic [NUM_SRC-1:0] src_wdata_i,
   input  logic               gie_wdata_i,
   output logic [NUM_SRC-1:0] stat_o,
   output logic [NUM_SRC-1:0] en_o,
   output logic               gie_o,
   output logic               irq_o
);
   logic [NUM_SRC-1:0] stat_q, en_q, pend;
   logic               gie_q;
   logic [NUM_SRC-1:0] w1c_mask;

   assign w1c_mask = stat_wr_i ? src_wdata_i : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stat_q <= '0;
         en_q   <= '0;
         gie_q  <= 1'b0;
      end else if (clr_i) begin
         stat_q <= '0;
         en_q   <= '0;
         gie_q  <= 1'b0;
      end else begin
         stat_q <= (stat_q & ~w1c_mask) | rise_i;
         if (en_wr_i)  en_q  <= src_wdata_i;
         if (gie_wr_i) gie_q <= gie_wdata_i;
      end
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_pend
      assign pend[i] = stat_q[i] & en_q[i];
   end

   if (IRQ_REG) begin : g_irq_flop
      logic irq_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)    irq_q <= 1'b0;
         else if (clr_i) irq_q <= 1'b0;
         else            irq_q <= gie_q & (|pend);
      end
      assign irq_o = irq_q;
      // R7: turning off the global enable drops the request two edges later
      p_irq_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (gie_wr_i && !gie_wdata_i && !clr_i) |=> ##1 !irq_o);
   end else begin : g_irq_comb
      assign irq_o = gie_q & (|pend);
      // R7: turning off the global enable drops the request after the edge
      p_irq_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (gie_wr_i && !gie_wdata_i && !clr_i) |=> !irq_o);
   end

   assign stat_o = stat_q;
   assign en_o   = en_q;
   assign gie_o  = gie_q;

   // R2: an edge always lands in status, enables or not
   p_rise_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((|rise_i) && !clr_i) |=> ((stat_q & $past(rise_i)) == $past(rise_i)));
   // R3: ones written to status are gone when no edge competes
   p_w1c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_wr_i && !clr_i && rise_i == '0) |=> ((stat_q & $past(src_wdata_i)) == '0));
   // R5: enable register holds its value without a write
   p_en_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_wr_i && !clr_i) |=> $stable(en_q));
   // R9: soft clear empties every register
   p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (stat_q == '0 && en_q == '0 && !gie_q));
endmodule

// File: rtl/intc_soft_reset.sv
module intc_soft_reset #(
   parameter int RST_CYCLES = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic hit_i,
   output logic core_rst_o
);
   localparam int CNT_W = $clog2(RST_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cnt_q <= '0;
      else if (hit_i)         cnt_q <= CNT_LOAD;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign core_rst_o = (cnt_q != '0);

   // independent run-length counter for the pulse-width check
   logic [CNT_W:0] run_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         run_q <= '0;
      else if (hit_i)      run_q <= '0;
      else if (core_rst_o) run_q <= run_q + 1'b1;
      else                 run_q <= '0;
   end

   // R8: the pulse starts the cycle after the key
   p_pulse_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_i |=> core_rst_o);
   // R8: the pulse never outlasts its configured width
   p_pulse_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      core_rst_o |-> (run_q < (CNT_W+1)'(RST_CYCLES)));
endmodule

// File: rtl/intc_softrst_top.sv
module intc_softrst_top #(
   parameter int NUM_SRC    = 7,
   parameter int ADDR_W     = 8,
   parameter int RST_CYCLES = 4,
   parameter bit IRQ_REG    = 1'b0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic               bus_wr_i,
   input  logic [31:0]        bus_wdata_i,
   output logic [31:0]        bus_rdata_o,
   input  logic [NUM_SRC-1:0] event_i,
   output logic               irq_o,
   output logic               core_rst_o
);
   import intc_pkg::*;

   if (NUM_SRC < 1 || NUM_SRC > 32) begin : g_bad_src
      $error("NUM_SRC must lie in 1..32");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must be at least 8");
   end
   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("RST_CYCLES must be at least 1");
   end

   reg_sel_e           sel;
   logic               wr_gie, wr_stat, wr_en, wr_rst, key_hit, clr;
   logic [NUM_SRC-1:0] rise, stat, en;
   logic               gie;

   always_comb begin
      if      (bus_addr_i == ADDR_W'(OFS_GIE))  sel = SEL_GIE;
      else if (bus_addr_i == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
      else if (bus_addr_i == ADDR_W'(OFS_EN))   sel = SEL_EN;
      else if (bus_addr_i == ADDR_W'(OFS_RST))  sel = SEL_RST;
      else                                      sel = SEL_NONE;
   end

   assign wr_gie  = bus_wr_i && (sel == SEL_GIE);
   assign wr_stat = bus_wr_i && (sel == SEL_STAT);
   assign wr_en   = bus_wr_i && (sel == SEL_EN);
   assign wr_rst  = bus_wr_i && (sel == SEL_RST);
   assign key_hit = wr_rst && (bus_wdata_i == RST_KEY);
   assign clr     = key_hit | core_rst_o;

   intc_edge_capture #(.NUM_SRC(NUM_SRC)) u_edge (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .event_i (event_i),
      .rise_o  (rise)
   );

   intc_status_regs #(.NUM_SRC(NUM_SRC), .IRQ_REG(IRQ_REG)) u_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_i       (clr),
      .rise_i      (rise),
      .stat_wr_i   (wr_stat),
      .en_wr_i     (wr_en),
      .gie_wr_i    (wr_gie),
      .src_wdata_i (bus_wdata_i[NUM_SRC-1:0]),
      .gie_wdata_i (bus_wdata_i[GIE_BIT]),
      .stat_o      (stat),
      .en_o        (en),
      .gie_o       (gie),
      .irq_o       (irq_o)
   );

   intc_soft_reset #(.RST_CYCLES(RST_CYCLES)) u_srst (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hit_i      (key_hit),
      .core_rst_o (core_rst_o)
   );

   always_comb begin
      bus_rdata_o = '0;
      unique case (sel)
         SEL_GIE:  bus_rdata_o[GIE_BIT]     = gie;
         SEL_STAT: bus_rdata_o[NUM_SRC-1:0] = stat;
         SEL_EN:   bus_rdata_o[NUM_SRC-1:0] = en;
         default:  bus_rdata_o = '0;
      endcase
   end

   // R10: a wrong key never starts a pulse
   p_nokey_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_rst && bus_wdata_i != RST_KEY && !core_rst_o) |=> !core_rst_o);
   // R11: reset register and unmapped offsets read as zero
   p_rd_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel == SEL_NONE || sel == SEL_RST) |-> (bus_rdata_o == '0));
endmodule

// File: tb/intc_softrst_top_tb.sv
module intc_softrst_top_tb;
   localparam int N = 7;
   localparam logic [31:0] M = 32'h7F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = 8'hFC;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [N-1:0] ev = '0;
   logic        irq, crst;
   int          checks = 0, errs = 0;
   bit          done = 1'b0;
   logic [31:0] exp_stat = 0, exp_en = 0;
   logic        exp_gie = 0;

   always #2 clk = ~clk;

   intc_softrst_top u_dut (
      .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .event_i(ev),
      .irq_o(irq), .core_rst_o(crst)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wreg(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0; addr = 8'hFC;
   endtask

   task automatic rreg(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); addr = a; #1 d = rdata;
   endtask

   task automatic pulse(input logic [N-1:0] p);
      @(negedge clk); ev = p;
      @(negedge clk); ev = '0;
   endtask

   task automatic check_all(input string tag);
      logic [31:0] d;
      rreg(8'h20, d); chk({tag, " status"}, d, exp_stat);
      rreg(8'h28, d); chk({tag, " enable"}, d, exp_en);
      rreg(8'h1C, d); chk({tag, " gie"}, d, {exp_gie, 31'b0});
      chk({tag, " irq"}, {31'b0, irq}, {31'b0, exp_gie & (|(exp_stat & exp_en))});
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog actual=hung expected=done");
         finish_run();
      end
   end

   initial begin
      logic [31:0] d;
      int highs;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check_all("R1");
      chk("R1 core_rst", {31'b0, crst}, 32'h0);

      // R5 enable width
      wreg(8'h28, 32'hFFFF_FFFF); exp_en = M;
      check_all("R5");
      // R6 only bit 31 stored
      wreg(8'h1C, 32'h7FFF_FFFF); exp_gie = 0;
      check_all("R6 low bits");
      wreg(8'h1C, 32'h8000_0000); exp_gie = 1;
      check_all("R6 bit31");

      // R2 / R7 / R3 sweep over every enable value and both gie settings
      for (int e = 0; e < 128; e++) begin
         for (int g = 0; g < 2; g++) begin
            logic [N-1:0] p;
            p = N'((e * 37 + 11 + g * 5) & 127);
            wreg(8'h28, 32'(e)); exp_en = 32'(e);
            wreg(8'h1C, g[0] ? 32'h8000_0000 : 32'h0); exp_gie = g[0];
            pulse(p); exp_stat = 32'(p);
            rreg(8'h20, d); chk("R2 latch", d, exp_stat);
            chk("R7 irq", {31'b0, irq}, {31'b0, exp_gie & (|(exp_stat & exp_en))});
            wreg(8'h20, 32'hFFFF_FFFF); exp_stat = 0;
            rreg(8'h20, d); chk("R3 clear all", d, 32'h0);
            chk("R7 irq idle", {31'b0, irq}, 32'h0);
         end
      end

      // R3 partial clear
      wreg(8'h28, 32'h7F); exp_en = M;
      wreg(8'h1C, 32'h8000_0000); exp_gie = 1;
      pulse(7'h7F); exp_stat = 32'h7F;
      wreg(8'h20, 32'h15); exp_stat = 32'h6A;
      check_all("R3 partial");

      // R4 event edge and clear of same bit in one cycle
      @(negedge clk); ev = 7'h02; addr = 8'h20; wdata = 32'h0A; wr = 1'b1;
      @(negedge clk); wr = 1'b0; addr = 8'hFC; ev = '0;
      exp_stat = 32'h62;
      check_all("R4 event wins");

      // R2 held-high line does not re-latch
      wreg(8'h20, 32'hFF); exp_stat = 0;
      @(negedge clk); ev = 7'h04;
      repeat (2) @(negedge clk);
      rreg(8'h20, d); chk("R2 held set", d, 32'h04);
      wreg(8'h20, 32'h04);
      repeat (3) @(negedge clk);
      rreg(8'h20, d); chk("R2 held no relatch", d, 32'h0);
      @(negedge clk); ev = '0;

      // R11 unmapped offsets
      pulse(7'h11); exp_stat = 32'h11;
      wreg(8'h24, 32'hFFFF_FFFF);
      wreg(8'h00, 32'hFFFF_FFFF);
      wreg(8'h2C, 32'h0);
      rreg(8'h24, d); chk("R11 read unmapped", d, 32'h0);
      rreg(8'h40, d); chk("R11 read reset reg", d, 32'h0);
      check_all("R11 state kept");

      // R10 wrong keys
      wreg(8'h40, 32'h0B);
      chk("R10 core_rst 0x0B", {31'b0, crst}, 32'h0);
      wreg(8'h40, 32'h10A);
      chk("R10 core_rst 0x10A", {31'b0, crst}, 32'h0);
      wreg(8'h40, 32'h0);
      chk("R10 core_rst 0x0", {31'b0, crst}, 32'h0);
      check_all("R10 state kept");

      // R8 / R9 key write
      wreg(8'h40, 32'h0A);
      #1 chk("R8 first cycle", {31'b0, crst}, 32'h1);
      highs = crst ? 1 : 0;
      for (int k = 0; k < 7; k++) begin
         @(negedge clk); #1 if (crst) highs++;
      end
      chk("R8 width", 32'(highs), 32'd4);
      exp_stat = 0; exp_en = 0; exp_gie = 0;
      check_all("R9 cleared");

      done = 1'b1;
      finish_run();
   end
endmodule